// File: doc/BRIEF.md
# CPU Clock Ratio Generator

This block turns one selectable reference strobe into four phase-aligned enable pulses for a processor complex. All logic runs on a single fast system clock. Each reference source arrives as a one-cycle strobe input, and the block selects one of them through a configuration word. A one-based prescaler divides the selected strobe. A small ratio sequencer then derives four outputs from the divided rate: a top-rate enable, a half-rate enable, a "2x" enable and a "1x" enable.

The two slowest outputs follow one of two ratio families, picked by a single mode bit. With the bit clear they divide the prescaled rate by 2 and 4. With the bit set they divide it by 3 and 6. The half-rate output always divides by 2. Each output has its own enable bit, and a change to an enable bit acts at once.

Changes to the source select, divisor or mode are held in a shadow copy. They move to the active configuration only when a full 1x period ends. The prescaler and the sequencer restart from that point, so no output period is ever cut short.

Top module: `ccr_ratio_gen`

## Requirements
- R1: After reset every output is low and the configuration word reads 0x0400_0000: only the 2x enable (bit 26) is set, the select, divisor and mode are 0.
- R2: A write stores the select (bits 5:4), divisor (bits 13:8), mode (bit 16) and enables (bits 27:24). The word reads back on the next cycle with every other bit zero, so writing all ones reads 0x0F01_3F30.
- R3: Select codes 0 and 1 both choose src_tick[0]. Code 2 chooses src_tick[1] and code 3 chooses src_tick[2].
- R4: The divisor D is one-based and D=0 is accepted: D=0 and D=1 pass every selected strobe, and D>=2 yields one divided pulse per D selected strobes. When enable bit 24 is set, out_top pulses for every divided pulse.
- R5: out_half (enable bit 25) pulses on every second divided pulse in both modes, starting with the first pulse after a period boundary.
- R6: With mode 0, out_2x (bit 26) and out_1x (bit 27) fire on every 2nd and 4th divided pulse. With mode 1 they fire on every 3rd and 6th. Both start with the first pulse of a period.
- R7: An enable bit that has been written gates its output from the next divided pulse on, with no wait for a period boundary.
- R8: When all enables are set, every out_1x pulse coincides with out_2x, out_half and out_top pulses.
- R9: A new select, divisor or mode takes effect only after the divided pulse that ends the current 1x period (the 4th or 6th of the period, per the active mode). The prescaler count and the phase then restart from zero.
- R10: Each output is a pulse one system-clock cycle wide. It appears in the cycle after the clock edge that samples the selected strobe completing a division.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write word |
| cfg_rdata | output | 32 | Current (shadow) configuration word |
| src_tick | input | 3 | One strobe per reference source |
| out_top | output | 1 | Top-rate enable pulse |
| out_half | output | 1 | Half-rate enable pulse |
| out_2x | output | 1 | 2x enable pulse |
| out_1x | output | 1 | 1x enable pulse |

## Verification
The assertions assume that the system clock is at least as fast as any reference strobe, so each strobe lasts exactly one sampled cycle. They also assume that a 1x pulse arrives at least two system cycles after the previous one, which holds because a 1x period spans four or more divided pulses. The stimulus draws every strobe pattern as per-cycle random bits on the system clock, at densities from sparse to every cycle. It uses divisors up to 7 and rewrites the configuration at arbitrary phases, including in the middle of a period and before the pending change is applied. Every output is compared each cycle with a behavioural model that tracks a shadow word and an active word separately.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
   // Field placement inside the configuration word
   localparam int SEL_LSB  = 4;
   localparam int DIV_LSB  = 8;
   localparam int MODE_BIT = 16;
   localparam int EN_LSB   = 24;
   localparam int OUT_N    = 4;

   // Output index order inside the enable field
   localparam int O_TOP  = 0;
   localparam int O_HALF = 1;
   localparam int O_2X   = 2;
   localparam int O_1X   = 3;

   // Longest ratio period (mode 1) and its phase counter width
   localparam int MAX_PERIOD = 6;
   localparam int PH_W       = $clog2(MAX_PERIOD);

   typedef enum logic {
      RATIO_2_4 = 1'b0,
      RATIO_3_6 = 1'b1
   } ratio_mode_e;
endpackage

// File: rtl/ccr_regs.sv
module ccr_regs #(
   parameter int DATA_W = 32,
   parameter int SEL_W  = 2,
   parameter int DIV_W  = 6
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we,
   input  logic [DATA_W-1:0]         wdata,
   output logic [DATA_W-1:0]         rdata,
   output logic [SEL_W-1:0]          sel,
   output logic [DIV_W-1:0]          div,
   output logic                      mode,
   output logic [ccr_pkg::OUT_N-1:0] en
);
   import ccr_pkg::*;

   localparam logic [DATA_W-1:0] ONE_W   = DATA_W'(1);
   localparam logic [DATA_W-1:0] WR_MASK =
      (((ONE_W << SEL_W) - ONE_W) << SEL_LSB) |
      (((ONE_W << DIV_W) - ONE_W) << DIV_LSB) |
      (ONE_W << MODE_BIT) |
      (((ONE_W << OUT_N) - ONE_W) << EN_LSB);
   localparam logic [DATA_W-1:0] RST_VAL = ONE_W << (EN_LSB + O_2X);

   logic [DATA_W-1:0] word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  word_q <= RST_VAL;
      else if (we) word_q <= wdata & WR_MASK;
   end

   assign rdata = word_q;
   assign sel   = word_q[SEL_LSB +: SEL_W];
   assign div   = word_q[DIV_LSB +: DIV_W];
   assign mode  = word_q[MODE_BIT];
   assign en    = word_q[EN_LSB +: OUT_N];

   // R2: no bit outside the defined fields may ever hold a one
   assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (word_q & ~WR_MASK) == '0);
endmodule

// File: rtl/ccr_srcmux.sv
module ccr_srcmux #(
   parameter int N_SRC = 3,
   parameter int SEL_W = 2
) (
   input  logic [N_SRC-1:0] tick,
   input  logic [SEL_W-1:0] sel,
   output logic             hit
);
   localparam int N_CODE = 1 << SEL_W;

   logic [N_CODE-1:0] by_code;

   // Codes 0 and 1 share the first source; code c>=2 maps to source c-1
   for (genvar c = 0; c < N_CODE; c++) begin : g_code
      localparam int IDX = (c <= 1) ? 0 : c - 1;
      if (IDX < N_SRC) begin : g_map
         assign by_code[c] = tick[IDX];
      end else begin : g_none
         assign by_code[c] = 1'b0;
      end
   end

   assign hit = by_code[sel];
endmodule

// File: rtl/ccr_prescale.sv
module ccr_prescale #(
   parameter int DIV_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             src,
   input  logic [DIV_W-1:0] div,
   output logic             pulse
);
   localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] last_cnt;

   // Zero and one both mean pass-through
   assign last_cnt = (div == '0) ? '0 : div - ONE;
   assign pulse    = src && (cnt == last_cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (pulse) cnt <= '0;
      else if (src)   cnt <= cnt + ONE;
   end

   // R4: count never passes the terminal value of the active divisor
   assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= last_cnt);
endmodule

// File: rtl/ccr_ratio.sv
module ccr_ratio (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 pulse,
   input  ccr_pkg::ratio_mode_e mode,
   output logic                 last,
   output logic                 raw_half,
   output logic                 raw_2x,
   output logic                 raw_1x
);
   import ccr_pkg::*;

   localparam logic [PH_W-1:0] ONE    = PH_W'(1);
   localparam logic [PH_W-1:0] END_24 = PH_W'(3);
   localparam logic [PH_W-1:0] END_36 = PH_W'(MAX_PERIOD - 1);
   localparam logic [PH_W-1:0] MID_36 = PH_W'(3);

   logic [PH_W-1:0] ph;
   logic [PH_W-1:0] end_ph;

   assign end_ph   = (mode == RATIO_3_6) ? END_36 : END_24;
   assign last     = (ph == end_ph);
   assign raw_half = !ph[0];
   assign raw_1x   = (ph == '0);
   assign raw_2x   = (mode == RATIO_3_6) ? ((ph == '0) || (ph == MID_36)) : !ph[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ph <= '0;
      else if (pulse) ph <= last ? '0 : ph + ONE;
   end

   assert_phase_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ph <= end_ph);
   assert_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse && last) |=> (ph == '0));
   assert_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
      raw_1x |-> (raw_2x && raw_half));
endmodule

// File: rtl/ccr_ratio_gen.sv
module ccr_ratio_gen #(
   parameter int DATA_W  = 32,
   parameter int N_SRC   = 3,
   parameter int SEL_W   = 2,
   parameter int DIV_W   = 6,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   input  logic [N_SRC-1:0]  src_tick,
   output logic              out_top,
   output logic              out_half,
   output logic              out_2x,
   output logic              out_1x
);
   import ccr_pkg::*;

   // Elaboration-time parameter checks
   if (DIV_W < 1 || DIV_LSB + DIV_W > MODE_BIT) begin : g_bad_div
      $error("ccr_ratio_gen: DIV_W does not fit below the mode bit");
   end
   if (SEL_LSB + SEL_W > DIV_LSB) begin : g_bad_sel
      $error("ccr_ratio_gen: SEL_W overlaps the divisor field");
   end
   if (N_SRC < 1 || N_SRC > (1 << SEL_W) - 1) begin : g_bad_src
      $error("ccr_ratio_gen: N_SRC not reachable by the select codes");
   end
   if (EN_LSB + OUT_N > DATA_W) begin : g_bad_data
      $error("ccr_ratio_gen: DATA_W too narrow for the enable field");
   end

   logic [SEL_W-1:0] sh_sel, act_sel;
   logic [DIV_W-1:0] sh_div, act_div;
   logic             sh_mode, act_mode;
   logic [OUT_N-1:0] en;
   logic             src_hit, dpulse, last, boundary;
   logic             raw_half, raw_2x, raw_1x;
   logic [OUT_N-1:0] fire;

   ccr_regs #(.DATA_W(DATA_W), .SEL_W(SEL_W), .DIV_W(DIV_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
      .rdata(cfg_rdata), .sel(sh_sel), .div(sh_div), .mode(sh_mode), .en(en)
   );

   // Active configuration only moves at the end of a 1x period
   assign boundary = dpulse && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_sel  <= '0;
         act_div  <= '0;
         act_mode <= 1'b0;
      end else if (boundary) begin
         act_sel  <= sh_sel;
         act_div  <= sh_div;
         act_mode <= sh_mode;
      end
   end

   ccr_srcmux #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_mux (
      .tick(src_tick), .sel(act_sel), .hit(src_hit)
   );

   ccr_prescale #(.DIV_W(DIV_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .src(src_hit), .div(act_div), .pulse(dpulse)
   );

   ccr_ratio u_ratio (
      .clk(clk), .rst_n(rst_n), .pulse(dpulse), .mode(ratio_mode_e'(act_mode)),
      .last(last), .raw_half(raw_half), .raw_2x(raw_2x), .raw_1x(raw_1x)
   );

   assign fire[O_TOP]  = dpulse && en[O_TOP];
   assign fire[O_HALF] = dpulse && raw_half && en[O_HALF];
   assign fire[O_2X]   = dpulse && raw_2x && en[O_2X];
   assign fire[O_1X]   = dpulse && raw_1x && en[O_1X];

   if (OUT_REG) begin : g_out_reg
      logic [OUT_N-1:0] fire_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) fire_q <= '0;
         else        fire_q <= fire;
      end
      assign {out_1x, out_2x, out_half, out_top} = fire_q;
   end else begin : g_out_comb
      assign {out_1x, out_2x, out_half, out_top} = fire;
   end

   assert_active_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !boundary |=> $stable({act_sel, act_div, act_mode}));
   assert_1x_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_1x |=> !out_1x);
   assert_1x_has_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fire[O_1X] && en[O_TOP]) |-> fire[O_TOP]);
endmodule

// File: tb/tb_ccr_ratio_gen.sv
module tb_ccr_ratio_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic [2:0]  src_tick = '0;
   logic        out_top, out_half, out_2x, out_1x;

   int    checks = 0;
   int    errors = 0;
   bit    done = 1'b0;
   string cur_tag = "R1";
   int    dens[3] = '{0, 0, 0};

   always #2.5 clk = ~clk;

   ccr_ratio_gen dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .src_tick(src_tick), .out_top(out_top),
      .out_half(out_half), .out_2x(out_2x), .out_1x(out_1x)
   );

   // ---------------- behavioural reference model ----------------
   int       m_cnt, m_ph, m_sel, m_div, m_mode;
   int       m_idx, m_lim, m_per;
   bit       m_src, m_p;
   bit [3:0] m_en;
   bit [3:0] en_used = '0;
   bit [31:0] m_sh = 32'h0400_0000;
   bit       e_top = 0, e_half = 0, e_2x = 0, e_1x = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_ph = 0; m_sel = 0; m_div = 0; m_mode = 0;
         m_sh = 32'h0400_0000;
         e_top = 0; e_half = 0; e_2x = 0; e_1x = 0; en_used = '0;
      end else begin
         m_idx = (m_sel <= 1) ? 0 : m_sel - 1;
         m_src = src_tick[m_idx];
         m_lim = (m_div == 0) ? 1 : m_div;
         m_per = m_mode ? 6 : 4;
         m_p   = m_src && (m_cnt == m_lim - 1);
         m_en  = m_sh[27:24];
         en_used = m_en;
         e_top  = m_p && m_en[0];
         e_half = m_p && (m_ph % 2 == 0) && m_en[1];
         e_2x   = m_p && (m_ph % (m_mode ? 3 : 2) == 0) && m_en[2];
         e_1x   = m_p && (m_ph == 0) && m_en[3];
         if (m_p) begin
            m_cnt = 0;
            if (m_ph == m_per - 1) begin
               m_ph = 0;
               m_sel = int'(m_sh[5:4]);
               m_div = int'(m_sh[13:8]);
               m_mode = int'(m_sh[16]);
            end else begin
               m_ph++;
            end
         end else if (m_src) begin
            m_cnt++;
         end
         if (cfg_we) m_sh = cfg_wdata & 32'h0F01_3F30;
      end
   end

   // ---------------- per-cycle comparison ----------------
   task automatic chk(input string req, input string what, input logic act, input bit exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s [%s] %s actual %0b expected %0b at %0t", req, cur_tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         chk("R4", "out_top", out_top, e_top);
         chk("R5", "out_half", out_half, e_half);
         chk("R6", "out_2x", out_2x, e_2x);
         chk("R6", "out_1x", out_1x, e_1x);
         if (e_1x && en_used == 4'hF) begin
            chk("R8", "1x coincident with 2x/half/top",
                out_2x && out_half && out_top, 1'b1);
         end
      end
   end

   // strobe generator
   always @(negedge clk) begin
      for (int i = 0; i < 3; i++) src_tick[i] <= ($urandom_range(99) < dens[i]);
   end

   task automatic wr(input logic [31:0] v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic run(input string tag, input int n, input int d0, input int d1, input int d2);
      cur_tag = tag;
      dens[0] = d0; dens[1] = d1; dens[2] = d2;
      repeat (n) @(negedge clk);
   endtask

   task automatic rd_chk(input string req, input logic [31:0] exp);
      checks++;
      if (cfg_rdata !== exp) begin
         errors++;
         $display("FAIL %s cfg_rdata actual %h expected %h", req, cfg_rdata, exp);
      end
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rd_chk("R1", 32'h0400_0000);
      checks++;
      if ({out_top, out_half, out_2x, out_1x} !== 4'b0000) begin
         errors++;
         $display("FAIL R1 outputs actual %b expected 0000", {out_top, out_half, out_2x, out_1x});
      end
      rst_n = 1'b1;

      run("R10", 200, 10, 0, 0);
      run("R4", 200, 100, 0, 0);

      wr(32'h0F00_0300);
      rd_chk("R2", 32'h0F00_0300);
      run("R4", 300, 70, 0, 0);

      wr(32'hFFFF_FFFF);
      rd_chk("R2", 32'h0F01_3F30);
      wr(32'h0F00_0100);
      rd_chk("R2", 32'h0F00_0100);
      run("R4", 100, 80, 0, 0);

      for (int k = 0; k < 20; k++) begin
         wr({4'h0, 4'($urandom_range(15)), 15'h0, 1'($urandom_range(1)), 8'h01, 8'h00});
         run("R7", 30, 80, 0, 0);
      end

      wr(32'h0F01_0100);
      run("R6", 400, 100, 0, 0);
      wr(32'h0F01_0200);
      run("R5", 400, 60, 0, 0);
      wr(32'h0F00_0000);
      run("R8", 300, 90, 0, 0);

      wr(32'h0F00_0210);
      run("R3", 300, 50, 15, 90);
      wr(32'h0F00_0220);
      run("R3", 300, 10, 60, 90);
      wr(32'h0F00_0230);
      run("R3", 300, 90, 20, 40);
      wr(32'h0F00_0200);
      run("R3", 200, 40, 90, 5);

      for (int k = 0; k < 40; k++) begin
         wr({4'h0, 4'hF, 7'h0, 1'($urandom_range(1)), 2'b00, 6'($urandom_range(7)),
             2'b00, 2'($urandom_range(3)), 4'h0});
         run("R9", $urandom_range(3, 40), 90, 70, 60);
      end
      run("R9", 400, 90, 70, 60);

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end
endmodule